// File: doc/BRIEF.md
# Data Bit Clock Generator and Bit Synchronizer

This block derives the bit-level clocking of a half-duplex radio data port from one reference clock. A single prescaler divides the reference by a programmable factor K. Two power-of-two selects then tap a shared binary counter behind it. One tap gives a tick stream at sixteen times the receive bit rate, which drives a bit synchronizer. The other gives a square-wave transmit bit clock.

In receive mode with synchronization enabled, the synchronizer follows the transitions of the demodulated bit stream. It adjusts a 16-step phase counter by one step per transition until the bit boundaries fall at step 0. It then samples each bit at step 8. The recovered bit appears on the data output in the same cycle that the bit clock rises, so the user samples on the falling edge.

In transmit mode with synchronization enabled, the bit clock runs at the transmit rate and the user's data is captured on each rising edge. With synchronization disabled, the bit clock stays low and both data paths pass straight through their registers.

Top module: `bitclk_sync`

## Requirements
- R1: In transmit mode with sync enabled, `bit_clk_o` is a square wave that stays high for K·2^(6−T) reference cycles and low for the same count, where T is `cfg_tx_sel` (0..6).
- R2: A prescaler value `cfg_k` of 0 divides exactly like a value of 1.
- R3: In receive mode with sync enabled and no input transitions, `bit_clk_o` has a period of 16·K·2^(7−S) reference cycles with equal high and low time, where S is `cfg_rx_sel` (0..7).
- R4: Whenever `sync_en` is 0, `bit_clk_o` is 0 from the next cycle on; all outputs are 0 after reset.
- R5: In receive mode with sync disabled, `rx_data_o` equals `rx_raw` delayed by exactly three reference cycles.
- R6: In transmit mode with sync disabled, `tx_bit_o` equals `tx_data` delayed by exactly one reference cycle.
- R7: In receive mode with sync enabled, `rx_data_o` changes only in the cycle in which `bit_clk_o` rises, and it then carries the bit at the sampling point.
- R8: Starting from any phase offset, with a transition in every bit, the sampling point settles within 22 bit periods to within a few steps of mid-bit.
- R9: In transmit mode with sync enabled, `tx_bit_o` takes the value of `tx_data` in the cycle `bit_clk_o` rises, and holds that value otherwise.
- R10: A change of `cfg_k`, `cfg_rx_sel` or `cfg_tx_sel` clears the divider counters. In transmit sync mode, the next rise of `bit_clk_o` then comes exactly K·2^(6−T)+2 cycles after the cycle in which the new value was applied.
- R11: A `cfg_tx_sel` value of 7 behaves as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_k | input | 6 | Prescaler factor K (0 acts as 1) |
| cfg_rx_sel | input | 3 | Power-of-two select for the 16x synchronizer tick |
| cfg_tx_sel | input | 3 | Power-of-two select for the transmit bit clock |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| sync_en | input | 1 | Enables the bit clock and the synchronizer |
| rx_raw | input | 1 | Demodulated receive bit, asynchronous |
| tx_data | input | 1 | User transmit bit |
| bit_clk_o | output | 1 | Data bit clock |
| rx_data_o | output | 1 | Retimed or pass-through receive data |
| tx_bit_o | output | 1 | Sampled transmit bit |

## Verification
The bench uses the default widths: a 6-bit K, 3-bit selects, a 16-step phase counter and a two-stage input synchronizer. With K=1 and receive select 7, the synchronizer ticks every reference cycle. A bit then lasts only 16 cycles, so a 60-bit lock run, including the worst-case half-bit start offset, fits easily in the cycle budget. Small K values with the higher selects keep the transmit periods in the tens of cycles. This lets the bench measure exact pulse widths and the exact restart latency after a field change. One low-select receive run still covers the longest divider chain.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  typedef enum logic {
    LINK_RX = 1'b0,
    LINK_TX = 1'b1
  } link_e;
endpackage

// File: rtl/bcs_prescaler.sv
`timescale 1ns/1ps
// Reference prescaler: one tick every K cycles, K of zero treated as one.
module bcs_prescaler #(
  parameter int K_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [K_W-1:0] k_val,
  output logic           tick
);
  logic [K_W-1:0] cnt_q;
  logic [K_W-1:0] k_eff;
  logic [K_W-1:0] k_last;

  always_comb begin
    k_eff  = (k_val == '0) ? {{(K_W-1){1'b0}}, 1'b1} : k_val;
    k_last = k_eff - 1'b1;
  end

  assign tick = (cnt_q >= k_last);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcs_pow2_div.sv
`timescale 1ns/1ps
// Shared binary counter with two power-of-two taps.
module bcs_pow2_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick_in,
  input  logic [SEL_W-1:0] rx_sel,
  input  logic [SEL_W-1:0] tx_sel,
  output logic             rx_tick,
  output logic             tx_lvl
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic             all_ones;
  int               tsel;

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt_q <= '0;
    else if (tick_in)  cnt_q <= cnt_q + 1'b1;
  end

  // Receive tick: the low (DIV_W - sel) bits all set on a prescaler tick.
  always_comb begin
    all_ones = 1'b1;
    for (int b = 0; b < DIV_W; b++) begin
      if (b < DIV_W - int'(rx_sel)) all_ones = all_ones & cnt_q[b];
    end
  end

  assign rx_tick = tick_in & all_ones;

  // Transmit level: bit (DIV_W-1 - sel), select clamped to DIV_W-1.
  always_comb begin
    tsel = int'(tx_sel);
    if (tsel > DIV_W - 1) tsel = DIV_W - 1;
    tx_lvl = cnt_q[DIV_W-1-tsel];
  end
endmodule

// File: rtl/bcs_sync.sv
`timescale 1ns/1ps
// Bit synchronizer: 2**PH_W steps per bit, boundary aimed at step 0,
// sample at the midpoint step.
module bcs_sync #(
  parameter int PH_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic din,
  output logic bclk,
  output logic dout
);
  localparam logic [PH_W-1:0] MID = PH_W'(1 << (PH_W - 1));

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_nx;
  logic            prev_q;
  logic            trans;

  always_comb begin
    trans = (din != prev_q);
    if (!trans || phase_q == '0)  phase_nx = phase_q + PH_W'(1);
    else if (phase_q < MID)       phase_nx = phase_q;
    else                          phase_nx = phase_q + PH_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      prev_q  <= 1'b0;
      bclk    <= 1'b0;
      dout    <= 1'b0;
    end else if (!run) begin
      phase_q <= '0;
      prev_q  <= din;
      bclk    <= 1'b0;
    end else if (tick) begin
      phase_q <= phase_nx;
      prev_q  <= din;
      bclk    <= phase_nx[PH_W-1];
      if (phase_nx == MID) dout <= din;
    end
  end
endmodule

// File: rtl/bitclk_sync.sv
`timescale 1ns/1ps
module bitclk_sync #(
  parameter int K_W         = 6,
  parameter int SEL_W       = 3,
  parameter int PH_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [K_W-1:0]   cfg_k,
  input  logic [SEL_W-1:0] cfg_rx_sel,
  input  logic [SEL_W-1:0] cfg_tx_sel,
  input  logic             mode_tx,
  input  logic             sync_en,
  input  logic             rx_raw,
  input  logic             tx_data,
  output logic             bit_clk_o,
  output logic             rx_data_o,
  output logic             tx_bit_o
);
  import bcs_pkg::*;

  localparam int CFG_W = K_W + 2 * SEL_W;

  link_e            mode;
  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             pre_tick;
  logic             rx_tick;
  logic             tx_lvl;
  logic             rx_s;
  logic             s_bclk;
  logic             s_dout;
  logic [SYNC_STAGES-1:0] rx_sh;

  assign mode    = link_e'(mode_tx);
  assign cfg_now = {cfg_k, cfg_rx_sel, cfg_tx_sel};
  assign cfg_chg = (cfg_now != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_now;
    else     cfg_q <= cfg_now;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) rx_sh <= '0;
        else     rx_sh <= rx_raw;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) rx_sh <= '0;
        else     rx_sh <= {rx_sh[SYNC_STAGES-2:0], rx_raw};
      end
    end
  endgenerate

  assign rx_s = rx_sh[SYNC_STAGES-1];

  bcs_prescaler #(.K_W(K_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (cfg_chg),
    .k_val (cfg_k),
    .tick  (pre_tick)
  );

  bcs_pow2_div #(.SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .clr     (cfg_chg),
    .tick_in (pre_tick),
    .rx_sel  (cfg_rx_sel),
    .tx_sel  (cfg_tx_sel),
    .rx_tick (rx_tick),
    .tx_lvl  (tx_lvl)
  );

  bcs_sync #(.PH_W(PH_W)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .run  (sync_en && (mode == LINK_RX)),
    .tick (rx_tick),
    .din  (rx_s),
    .bclk (s_bclk),
    .dout (s_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_clk_o <= 1'b0;
      rx_data_o <= 1'b0;
      tx_bit_o  <= 1'b0;
    end else if (mode == LINK_TX) begin
      rx_data_o <= rx_s;
      if (sync_en) begin
        bit_clk_o <= tx_lvl;
        if (tx_lvl && !bit_clk_o) tx_bit_o <= tx_data;
      end else begin
        bit_clk_o <= 1'b0;
        tx_bit_o  <= tx_data;
      end
    end else begin
      tx_bit_o  <= tx_data;
      bit_clk_o <= sync_en ? s_bclk : 1'b0;
      rx_data_o <= sync_en ? s_dout : rx_s;
    end
  end
endmodule

// File: rtl/bcs_checker.sv
`timescale 1ns/1ps
module bcs_checker #(
  parameter int RX_DLY = 3
) (
  input logic clk,
  input logic rst,
  input logic mode_tx,
  input logic sync_en,
  input logic rx_raw,
  input logic tx_data,
  input logic bit_clk_o,
  input logic rx_data_o,
  input logic tx_bit_o
);
  logic [3:0] age_q;
  logic       aged;

  always_ff @(posedge clk) begin
    if (rst)                age_q <= '0;
    else if (age_q != 4'hF) age_q <= age_q + 4'd1;
  end
  assign aged = (int'(age_q) > RX_DLY);

  // R4
  clk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> !bit_clk_o);

  // R6
  tx_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_tx && !sync_en) |=> (tx_bit_o == $past(tx_data)));

  // R5
  rx_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (aged && !mode_tx && !sync_en) |=> (rx_data_o == $past(rx_raw, RX_DLY)));

  // R7
  rx_update_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rx_data_o) && $past(!mode_tx && sync_en) && $past(!mode_tx && sync_en, 2))
      |-> $rose(bit_clk_o));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tx_bit_o) && $past(mode_tx && sync_en)) |-> $rose(bit_clk_o));
endmodule

bind bitclk_sync bcs_checker #(.RX_DLY(SYNC_STAGES + 1)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_tx   (mode_tx),
  .sync_en   (sync_en),
  .rx_raw    (rx_raw),
  .tx_data   (tx_data),
  .bit_clk_o (bit_clk_o),
  .rx_data_o (rx_data_o),
  .tx_bit_o  (tx_bit_o)
);

// File: tb/bitclk_sync_bench.sv
`timescale 1ns/1ps
module bitclk_sync_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cfg_k = 6'd1;
  logic [2:0] cfg_rx_sel = 3'd7;
  logic [2:0] cfg_tx_sel = 3'd6;
  logic       mode_tx = 1'b0;
  logic       sync_en = 1'b0;
  logic       rx_raw = 1'b0;
  logic       tx_data = 1'b0;
  logic       bit_clk_o, rx_data_o, tx_bit_o;

  int n_chk = 0;
  int n_fail = 0;
  bit drv[0:63];
  bit bitv[0:63];

  always #2.5 clk = ~clk;

  bitclk_sync u_bitclk_sync (
    .clk(clk), .rst(rst), .cfg_k(cfg_k), .cfg_rx_sel(cfg_rx_sel),
    .cfg_tx_sel(cfg_tx_sel), .mode_tx(mode_tx), .sync_en(sync_en),
    .rx_raw(rx_raw), .tx_data(tx_data), .bit_clk_o(bit_clk_o),
    .rx_data_o(rx_data_o), .tx_bit_o(tx_bit_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int half_tx(input int k, input int s);
    int kk = (k == 0) ? 1 : k;
    int ss = (s > 6) ? 6 : s;
    return kk * (1 << (6 - ss));
  endfunction

  function automatic int half_rx(input int k, input int s);
    int kk = (k == 0) ? 1 : k;
    return kk * 8 * (1 << (7 - s));
  endfunction

  task automatic measure(output int hi, output int lo);
    while (bit_clk_o !== 1'b0) @(negedge clk);
    while (bit_clk_o !== 1'b1) @(negedge clk);
    hi = 0;
    while (bit_clk_o === 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (bit_clk_o === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic restart_latency(input int k, input int s, input string req);
    int d = 0;
    bit prev;
    @(negedge clk);
    cfg_k = 6'(k); cfg_tx_sel = 3'(s);
    prev = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      d++;
      if (i > 0 && bit_clk_o && !prev) break;
      if (i > 0) prev = bit_clk_o;
    end
    check(d == half_tx(k, s) + 2, req, d, half_tx(k, s) + 2);
  endtask

  task automatic lock_run(input int off);
    bit prev_clk = 1'b0;
    int hits = 0;
    @(negedge clk);
    mode_tx = 1'b0; sync_en = 1'b0; cfg_k = 6'd1; cfg_rx_sel = 3'd7; rx_raw = 1'b0;
    repeat (4) @(negedge clk);
    sync_en = 1'b1;
    repeat (off) @(negedge clk);
    for (int i = 0; i < 60; i++) bitv[i] = (i < 22) ? ((i % 2) == 0) : 1'($urandom);
    for (int c = 0; c < 60 * 16; c++) begin
      @(negedge clk);
      if (c >= 22 * 16 && bit_clk_o && !prev_clk) begin
        int pos = (c - 4) % 16;
        hits++;
        check(pos >= 4 && pos <= 11, "R8 sample point", pos, 7);
        check(rx_data_o == bitv[(c - 4) / 16], "R7 recovered bit",
              int'(rx_data_o), int'(bitv[(c - 4) / 16]));
      end
      prev_clk = bit_clk_o;
      rx_raw = bitv[c / 16];
    end
    check(hits >= 30, "R8 bit clock after lock", hits, 38);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all R): actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int hi, lo, k, s;
    bit held;
    bit prev_clk;
    bit seen;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(bit_clk_o == 1'b0, "R4 reset clock", int'(bit_clk_o), 0);
    check(rx_data_o == 1'b0, "R4 reset rx data", int'(rx_data_o), 0);
    check(tx_bit_o == 1'b0, "R4 reset tx bit", int'(tx_bit_o), 0);
    rst = 1'b0;

    // R5 / R4: receive pass-through, clock held low
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i >= 3) check(rx_data_o == drv[i-3], "R5 pass-through", int'(rx_data_o), int'(drv[i-3]));
      check(bit_clk_o == 1'b0, "R4 clock low", int'(bit_clk_o), 0);
      drv[i] = 1'($urandom);
      rx_raw = drv[i];
    end

    // R6: transmit pass-through
    @(negedge clk); mode_tx = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i >= 1) check(tx_bit_o == drv[i-1], "R6 tx pass-through", int'(tx_bit_o), int'(drv[i-1]));
      drv[i] = 1'($urandom);
      tx_data = drv[i];
    end

    // R1 / R2 / R11: transmit clock widths
    @(negedge clk); sync_en = 1'b1; cfg_k = 6'd0; cfg_tx_sel = 3'd6;
    measure(hi, lo);
    check(hi == half_tx(0, 6) && lo == half_tx(0, 6), "R2 K zero", hi, half_tx(0, 6));
    cfg_k = 6'd1; cfg_tx_sel = 3'd6;
    measure(hi, lo);
    check(hi == 1 && lo == 1, "R1 fastest", hi, 1);
    cfg_k = 6'd3; cfg_tx_sel = 3'd7;
    measure(hi, lo);
    check(hi == half_tx(3, 7) && lo == half_tx(3, 7), "R11 select 7", lo, half_tx(3, 7));
    for (int i = 0; i < 6; i++) begin
      k = 1 + int'($urandom % 10);
      s = 3 + int'($urandom % 5);
      cfg_k = 6'(k); cfg_tx_sel = 3'(s);
      measure(hi, lo);
      check(hi == half_tx(k, s), "R1 high time", hi, half_tx(k, s));
      check(lo == half_tx(k, s), "R1 low time", lo, half_tx(k, s));
    end

    // R9: transmit capture on rising bit clock
    cfg_k = 6'd2; cfg_tx_sel = 3'd4;
    prev_clk = 1'b1; seen = 1'b0; held = 1'b0;
    for (int c = 0; c < 240; c++) begin
      @(negedge clk);
      if (bit_clk_o && !prev_clk) begin
        check(tx_bit_o == tx_data, "R9 capture", int'(tx_bit_o), int'(tx_data));
        held = tx_bit_o; seen = 1'b1;
      end else if (seen) begin
        check(tx_bit_o == held, "R9 hold", int'(tx_bit_o), int'(held));
      end
      if (!bit_clk_o && prev_clk) tx_data = 1'($urandom);
      prev_clk = bit_clk_o;
    end

    // R10: exact restart after field changes
    cfg_k = 6'd5; cfg_tx_sel = 3'd5;
    repeat (13) @(negedge clk);
    restart_latency(3, 5, "R10 change K");
    while (bit_clk_o !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    restart_latency(3, 4, "R10 change select while high");
    restart_latency(7, 6, "R10 change both");

    // R3: receive tick rate through the bit clock
    @(negedge clk); mode_tx = 1'b0; rx_raw = 1'b0;
    cfg_k = 6'd2; cfg_rx_sel = 3'd5;
    measure(hi, lo);
    check(hi == half_rx(2, 5) && lo == half_rx(2, 5), "R3 K2 S5", hi, half_rx(2, 5));
    cfg_k = 6'd3; cfg_rx_sel = 3'd7;
    measure(hi, lo);
    check(hi == half_rx(3, 7) && lo == half_rx(3, 7), "R3 K3 S7", hi, half_rx(3, 7));
    cfg_k = 6'd1; cfg_rx_sel = 3'd0;
    measure(hi, lo);
    check(hi == half_rx(1, 0) && lo == half_rx(1, 0), "R3 K1 S0", lo, half_rx(1, 0));

    // R7 / R8: lock from worst-case and random offsets
    lock_run(8);
    lock_run(int'($urandom % 16));

    finish_run();
  end
endmodule